// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital control core of a successive-approximation sampling converter, written as a cycle-based model. It watches two active-low strobes, a chip select and a convert-start. From them it moves between three phases: waiting for selection, acquiring the input, and converting. The busy output is high for the whole of a conversion. A result word from the comparator and register core is an input here. The sequencer latches that word into its output register on the cycle busy falls.

Every time constant is a parameter expressed in clock cycles: conversion length, minimum acquisition, minimum start-pulse width and the idle gap after which a sample counts as stale. Two events abort a conversion in progress and clear the output latches: a new start edge while selected, or a fresh select edge. After power-up the first results are flagged as untrustworthy. So is any result taken after a long idle gap. Start attempts that break the acquisition or pulse-width rules are refused, and each refusal is reported by a one-cycle error pulse.

Top module: `ssq_conv_ctrl`

## Requirements
- R1: During and straight after reset, `busy`, `rule_err` and `result_ok` are 0 and `result` is all zeros.
- R2: A convert-start fall is a `convst_n` value of 1 at one clock edge followed by 0 at the next. Such a fall, sampled with `cs_n` low during an acquisition that is long enough (R6), makes `busy` high from that edge on for exactly CONV_CYC cycles.
- R3: A convert-start fall sampled while `cs_n` is high is ignored. `busy` stays low and `rule_err` stays low.
- R4: On the edge where `busy` falls at the natural end of a conversion, `result` takes the value of `core_result` sampled at that edge. Before that edge, `result` keeps the earlier value for the whole conversion.
- R5: After reset, the first WARMUP results that complete have `result_ok` = 0. Later results have `result_ok` = 1 unless R10 applies.
- R6: Acquisition begins at the edge where `busy` falls if `cs_n` is low. Otherwise it begins at the first edge that samples `cs_n` low while idle. Take the edge that begins acquisition as edge 0. A start fall sampled at edge ACQ_MIN or later is accepted. An earlier start fall is refused: `busy` stays low and `rule_err` is high for one cycle.
- R7: A conversion is cancelled if `convst_n` is sampled high before it has been sampled low at PULSE_MIN consecutive edges, counting the start edge. On cancellation `busy` falls, `rule_err` pulses for one cycle, `result` is unchanged and the warm-up count does not advance.
- R8: A convert-start fall sampled with `cs_n` low during a conversion aborts it. At the next cycle `busy`, `result` and `result_ok` are all 0, and a new acquisition starts.
- R9: A chip-select fall (`cs_n` 1 then 0) sampled during a conversion aborts it in the same way as R8.
- R10: If more than STALE_CYC cycles have passed between the end of the previous completed conversion and the start of the current one, the current result has `result_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cs_n | input | 1 | Active-low chip select |
| convst_n | input | 1 | Active-low convert-start strobe |
| core_result | input | RES_W | Result word from the comparator and register core |
| busy | output | 1 | High while a conversion is running |
| result | output | RES_W | Output latch holding the last completed result |
| result_ok | output | 1 | High when the latched result is trustworthy |
| rule_err | output | 1 | One-cycle pulse on a refused or cancelled start |

## Verification
Some rules are checked by the assertions on every cycle. `busy` only rises after a start fall sampled with select low. The output latch and the trust flag only change on a busy fall. An error pulse never coincides with a running conversion. The internal counters never pass their limits. Other behaviour can only be shown by the bench's scenarios: the exact conversion length, the acquisition-length boundary, cancellation on a short pulse, aborts by either strobe, the warm-up count and the stale-gap flag. The bench sweeps the acquisition delay and the pulse width across their thresholds.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_ACQ  = 2'd1,
      ST_CONV = 2'd2
   } ssq_state_e;
endpackage

// File: rtl/ssq_fall_det.sv
module ssq_fall_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_i,
   output logic [N-1:0] fall_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= sig_i[i];
         end
         assign fall_o[i] = prev_q & ~sig_i[i];
      end
   endgenerate
endmodule

// File: rtl/ssq_sat_cnt.sv
module ssq_sat_cnt #(
   parameter int MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic top_o
);
   localparam int W = (MAX < 2) ? 1 : $clog2(MAX + 1);
   localparam logic [W-1:0] MAX_V = W'(MAX);

   if (MAX < 1) begin : g_bad_max
      $error("ssq_sat_cnt: MAX must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr_i)                 cnt_q <= '0;
      else if (inc_i && cnt_q != MAX_V) cnt_q <= cnt_q + 1'b1;
   end

   assign top_o = (cnt_q == MAX_V);

   // R6 R7 R10: counters that time the rules never run past their limit
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= MAX_V);
endmodule

// File: rtl/ssq_conv_ctrl.sv
module ssq_conv_ctrl
   import ssq_pkg::*;
#(
   parameter int RES_W     = 18,
   parameter int CONV_CYC  = 63,
   parameter int ACQ_MIN   = 25,
   parameter int PULSE_MIN = 2,
   parameter int STALE_CYC = 100000,
   parameter int WARMUP    = 3,
   parameter bit STALE_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             convst_n,
   input  logic [RES_W-1:0] core_result,
   output logic             busy,
   output logic [RES_W-1:0] result,
   output logic             result_ok,
   output logic             rule_err
);
   localparam int CONV_MAX  = CONV_CYC - 1;
   localparam int ACQ_MAX   = ACQ_MIN - 1;
   localparam int PULSE_MAX = PULSE_MIN - 1;
   localparam int GAP_MAX   = STALE_CYC + 1;

   if (RES_W < 1)     begin : g_bad_w     $error("RES_W must be at least 1");     end
   if (CONV_CYC < 2)  begin : g_bad_conv  $error("CONV_CYC must be at least 2");  end
   if (ACQ_MIN < 2)   begin : g_bad_acq   $error("ACQ_MIN must be at least 2");   end
   if (PULSE_MIN < 2) begin : g_bad_pulse $error("PULSE_MIN must be at least 2"); end
   if (WARMUP < 1)    begin : g_bad_warm  $error("WARMUP must be at least 1");    end
   if (STALE_CYC < 1) begin : g_bad_stale $error("STALE_CYC must be at least 1"); end

   ssq_state_e state_q, state_d;
   logic [1:0] falls;
   logic       cs_fall, cv_fall;
   logic       conv_top, acq_top, pulse_top, warm_top, stale_now;
   logic       in_conv, in_acq, in_wait;
   logic       start, reject, abort_c, cancel, done;
   logic       acq_clr;
   logic       stale_q;
   logic [RES_W-1:0] result_q;
   logic       ok_q, err_q;

   ssq_fall_det #(.N(2)) i_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i ({cs_n, convst_n}),
      .fall_o(falls)
   );
   assign cs_fall = falls[1];
   assign cv_fall = falls[0];

   assign in_conv = (state_q == ST_CONV);
   assign in_acq  = (state_q == ST_ACQ);
   assign in_wait = (state_q == ST_WAIT);

   // event decode, abort first, then cancel, then completion
   assign start   = in_acq && cv_fall && !cs_n && acq_top;
   assign reject  = cv_fall && !cs_n && (in_wait || (in_acq && !acq_top));
   assign abort_c = in_conv && ((cv_fall && !cs_n) || cs_fall);
   assign cancel  = in_conv && !abort_c && convst_n && !pulse_top;
   assign done    = in_conv && !abort_c && !cancel && conv_top;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WAIT: if (!cs_n) state_d = ST_ACQ;
         ST_ACQ:  if (start) state_d = ST_CONV;
         ST_CONV: begin
            if (abort_c)             state_d = ST_ACQ;
            else if (cancel || done) state_d = cs_n ? ST_WAIT : ST_ACQ;
         end
         default: state_d = ST_WAIT;
      endcase
   end

   assign acq_clr = (state_d == ST_ACQ) && !in_acq;

   ssq_sat_cnt #(.MAX(CONV_MAX)) i_conv_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start), .inc_i(in_conv), .top_o(conv_top));

   ssq_sat_cnt #(.MAX(ACQ_MAX)) i_acq_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(acq_clr), .inc_i(in_acq), .top_o(acq_top));

   ssq_sat_cnt #(.MAX(PULSE_MAX)) i_pulse_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start), .inc_i(in_conv && !convst_n),
      .top_o(pulse_top));

   ssq_sat_cnt #(.MAX(WARMUP)) i_warm_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .inc_i(done), .top_o(warm_top));

   generate
      if (STALE_EN) begin : g_gap
         ssq_sat_cnt #(.MAX(GAP_MAX)) i_gap_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(done), .inc_i(1'b1), .top_o(stale_now));
      end else begin : g_no_gap
         assign stale_now = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         stale_q  <= 1'b0;
         result_q <= '0;
         ok_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= reject || cancel;
         if (start) stale_q <= stale_now;
         if (abort_c) begin
            result_q <= '0;
            ok_q     <= 1'b0;
         end else if (done) begin
            result_q <= core_result;
            ok_q     <= warm_top && !stale_q;
         end
      end
   end

   assign busy      = in_conv;
   assign result    = result_q;
   assign result_ok = ok_q;
   assign rule_err  = err_q;

   // R2 R3: busy only rises after a start fall sampled with select low
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(convst_n) == 1'b0 && $past(cs_n) == 1'b0));

   // R4 R8: the output latch only moves when busy falls
   result_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $fell(busy));

   // R5 R10: the trust flag only rises when a conversion ends
   ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_ok) |-> $fell(busy));

   // R6 R7: an error pulse never overlaps a running conversion
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rule_err |-> !busy);

   // R8 R9: an abort leaves a cleared latch
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && result_ok) |-> !$past(cs_fall));
endmodule

// File: tb/test_ssq_conv_ctrl.sv
module test_ssq_conv_ctrl;
   localparam int W  = 18;
   localparam int CC = 8;
   localparam int AM = 4;
   localparam int PM = 2;
   localparam int SC = 60;
   localparam int WU = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic convst_n = 1'b1;
   logic [W-1:0] core = '0;
   logic busy, result_ok, rule_err;
   logic [W-1:0] result;
   logic [W-1:0] last = '0;
   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   ssq_conv_ctrl #(
      .RES_W(W), .CONV_CYC(CC), .ACQ_MIN(AM), .PULSE_MIN(PM),
      .STALE_CYC(SC), .WARMUP(WU), .STALE_EN(1'b1)
   ) i_ssq_conv_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n),
      .core_result(core), .busy(busy), .result(result),
      .result_ok(result_ok), .rule_err(rule_err)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nx(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [W-1:0] pat(input int k);
      return W'(k * 40503 + 7);
   endfunction

   // full conversion started at the current falling clock edge
   task automatic conv(input logic [W-1:0] v, input bit exp_ok);
      core = v;
      convst_n = 1'b0;
      nx(1);
      chk("R2 busy rise", busy, 1);
      chk("R4 result held at start", result, last);
      nx(1);
      convst_n = 1'b1;
      nx(CC - 2);
      chk("R2 busy through last cycle", busy, 1);
      chk("R4 result held late", result, last);
      nx(1);
      chk("R2 busy fall", busy, 0);
      chk("R4 result latched", result, v);
      chk("R5 R10 trust flag", result_ok, exp_ok);
      last = v;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      nx(2);
      chk("R1 busy in reset", busy, 0);
      chk("R1 result in reset", result, 0);
      chk("R1 ok in reset", result_ok, 0);
      chk("R1 err in reset", rule_err, 0);
      rst_n = 1'b1;
      nx(1);
      chk("R1 busy after reset", busy, 0);

      // R3: deselected start is ignored
      convst_n = 1'b0;
      nx(1);
      chk("R3 no busy when deselected", busy, 0);
      chk("R3 no error when deselected", rule_err, 0);
      convst_n = 1'b1;
      nx(2);
      chk("R3 still idle", busy, 0);

      cs_n = 1'b0;
      nx(AM + 2);
      // R5: warm-up results flagged
      for (int k = 0; k < WU; k++) begin
         conv(pat(k), 1'b0);
         nx(AM + 1);
      end
      conv('1, 1'b1);

      // R6: acquisition delay sweep after a busy fall
      for (int d = 0; d <= AM + 1; d++) begin
         nx(d);
         if (d < AM - 1) begin
            convst_n = 1'b0;
            nx(1);
            chk("R6 short acquisition refused", busy, 0);
            chk("R6 error pulse", rule_err, 1);
            convst_n = 1'b1;
            nx(1);
            chk("R6 error one cycle", rule_err, 0);
            nx(AM + 1);
            conv(pat(d + 10), 1'b1);
         end else begin
            conv(pat(d + 20), 1'b1);
         end
      end

      // R7: start pulse widths below the minimum cancel
      for (int w = 1; w < PM; w++) begin
         nx(AM + 1);
         core = pat(99);
         convst_n = 1'b0;
         nx(w);
         chk("R7 busy during short pulse", busy, 1);
         convst_n = 1'b1;
         nx(1);
         chk("R7 cancelled busy", busy, 0);
         chk("R7 cancel error", rule_err, 1);
         chk("R7 result unchanged", result, last);
      end
      nx(AM + 1);
      conv(0, 1'b1);

      // R8: abort by a new start edge
      nx(AM + 1);
      core = pat(50);
      convst_n = 1'b0;
      nx(1);
      chk("R8 busy before abort", busy, 1);
      nx(1);
      convst_n = 1'b1;
      nx(1);
      convst_n = 1'b0;
      nx(1);
      chk("R8 busy cleared", busy, 0);
      chk("R8 result cleared", result, 0);
      chk("R8 ok cleared", result_ok, 0);
      last = '0;
      convst_n = 1'b1;
      nx(AM + 1);
      conv(pat(51), 1'b1);

      // R9: abort by a select edge
      nx(AM + 1);
      core = pat(60);
      convst_n = 1'b0;
      nx(2);
      convst_n = 1'b1;
      cs_n = 1'b1;
      nx(1);
      chk("R9 busy with select high", busy, 1);
      cs_n = 1'b0;
      nx(1);
      chk("R9 busy cleared", busy, 0);
      chk("R9 result cleared", result, 0);
      chk("R9 ok cleared", result_ok, 0);
      last = '0;
      nx(AM + 1);
      conv(pat(61), 1'b1);

      // R6 R3: completion while deselected, then acquisition from select
      nx(AM + 1);
      core = pat(70);
      convst_n = 1'b0;
      nx(2);
      convst_n = 1'b1;
      cs_n = 1'b1;
      nx(CC - 1);
      chk("R4 ends while deselected", busy, 0);
      chk("R4 result while deselected", result, pat(70));
      last = pat(70);
      convst_n = 1'b0;
      nx(1);
      chk("R3 ignored while waiting", busy, 0);
      chk("R3 no error while waiting", rule_err, 0);
      convst_n = 1'b1;
      nx(2);
      cs_n = 1'b0;
      nx(AM - 1);
      convst_n = 1'b0;
      nx(1);
      chk("R6 refused from select", rule_err, 1);
      convst_n = 1'b1;
      nx(AM + 1);
      conv(pat(71), 1'b1);

      // R10: stale gap
      nx(SC + 20);
      conv(pat(80), 1'b0);
      nx(AM);
      conv(pat(81), 1'b1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule